// File: doc/BRIEF.md
# Flash Interrupt and Status Unit

This block keeps the completion and error bookkeeping of a NAND-style flash controller. It holds four registers: a controller status register with error flags, an interrupt status register with a master pending flag and one completion flag per operation kind, and two system configuration words. Software reaches them through a plain 16-bit register port. A separate command engine reports finished operations and failures to the block as single-cycle pulses.

The block drives a level interrupt line whose polarity comes from a configuration bit. It also drives a ready line, which the software sets through the first configuration word, and a command-accept gate. While an interrupt is pending, the gate stops the software from starting a new command. A synchronous reset carries a cold/warm select, and each kind of reset leaves a different completion flag set. An interrupt acknowledge that drops the pending flag also wipes the error flags.

Top module: `flash_irq_status`

## Requirements
- R1: A cold reset (`rst` high with `rst_cold` high at a clock edge) loads these values:
  - interrupt status 0x8080 and controller status 0x0000;
  - configuration word 1 0x40C0 and configuration word 2 0x0000;
  - command register 0x0000 and `ready` 1.
- R2: A warm reset (`rst` high with `rst_cold` low) loads the same values as R1, except that interrupt status becomes 0x8010.
- R3: A pulse on `done_evt[k]` sets interrupt-status bit 15 and bit 4+k in the next cycle. The kinds are k=0 reset, k=1 erase, k=2 program and k=3 load.
- R4: A pulse on `err_evt[k]` sets controller-status bit 10 (command error) and bit 11+k in the next cycle. The kinds are k=0 erase, k=1 program and k=2 load. Controller-status bits outside 13:10 always read 0.
- R5: A pulse on `bad_cmd` sets controller-status bit 10 and interrupt-status bit 15.
- R6: A write to the interrupt status register (address 1) replaces it with the bitwise AND of its old value and the written value.
- R7: When interrupt-status bit 15 is clear after an interrupt status write, controller-status bits 13:10 become 0 in the same cycle. If bit 15 stays set, they are kept.
- R8: `irq` equals interrupt-status bit 15 XOR the inverse of configuration-1 bit 6. Bit 6 set gives active-high signalling; bit 6 clear gives active-low signalling.
- R9: A write to the command register (address 4) is refused while interrupt-status bit 15 is set. `cmd_accept` shows the inverse of that bit. An accepted write pulses `cmd_go` in the same cycle and stores the code, which is shown on `cmd_code` and read back at address 4.
- R10: Writes to addresses 2 and 3 store configuration words 1 and 2. Reading address 2 returns word 1 with bits 4:0 forced to 0.
- R11: A write to configuration word 1 drives `ready` from bit 7 of the written value in the next cycle.
- R12: A completion, error or bad-command pulse in the same cycle as an interrupt status write is applied after the AND, so its flags survive. If the pulse sets bit 15, the error flags are kept.
- R13: The read map is:
  - address 0: controller status;
  - address 1: interrupt status;
  - address 2: configuration word 1;
  - address 3: configuration word 2;
  - address 4: command;
  - any other address: 0.

  Writes to address 0 and to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rst_cold | input | 1 | Reset kind while `rst` is high: 1 cold, 0 warm |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| done_evt | input | 4 | Completion pulses: 0 reset, 1 erase, 2 program, 3 load |
| err_evt | input | 3 | Failure pulses: 0 erase, 1 program, 2 load |
| bad_cmd | input | 1 | Unrecognised command code pulse |
| cmd_go | output | 1 | Accepted command write, one cycle |
| cmd_code | output | 16 | Last accepted command code |
| cmd_accept | output | 1 | High when a command write would be accepted |
| irq | output | 1 | Interrupt level, polarity from configuration-1 bit 6 |
| ready | output | 1 | Ready level, taken from configuration-1 bit 7 on write |

## Verification
Directed sequences drive each completion kind and each error kind on its own. These single-kind runs catch wrong bit positions and kinds that have been swapped. Acknowledges are written with bit 15 both kept and dropped, which separates the error-wipe condition from a plain AND. Pulses that coincide with an acknowledge show whether events outrank the clear. Seeded random traffic then mixes writes to every address with sparse pulses. In that traffic, command refusal, polarity flips and the low-bit masking on reads meet in combinations that a bench model, written from the requirements, must track cycle by cycle.

// File: rtl/fis_pkg.sv
package fis_pkg;
   localparam int REG_W       = 16;
   localparam int ADDR_W      = 3;
   localparam int NUM_DONE    = 4;
   localparam int NUM_ERRK    = 3;
   localparam int PEND_BIT    = 15;
   localparam int DONE_LSB    = 4;
   localparam int ERR_LSB     = 10;
   localparam int POL_BIT     = 6;
   localparam int RDY_BIT     = 7;
   localparam int RD_MASK_LO  = 5;

   typedef enum logic [ADDR_W-1:0] {
      A_CTRL = 3'd0,
      A_INT  = 3'd1,
      A_CFG1 = 3'd2,
      A_CFG2 = 3'd3,
      A_CMD  = 3'd4
   } reg_addr_e;
endpackage

// File: rtl/fis_int_reg.sv
module fis_int_reg
   import fis_pkg::*;
#(
   parameter int               DW       = REG_W,
   parameter int               NDONE    = NUM_DONE,
   parameter logic [DW-1:0]    COLD_VAL = 16'h8080,
   parameter logic [DW-1:0]    WARM_VAL = 16'h8010
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rst_cold,
   input  logic             wr,
   input  logic [DW-1:0]    wdata,
   input  logic [NDONE-1:0] done,
   input  logic             bad_cmd,
   input  logic             pol_high,
   output logic [DW-1:0]    int_q,
   output logic             clr_err,
   output logic             irq
);
   localparam int TOP_DONE = DONE_LSB + NDONE - 1;

   if (TOP_DONE >= PEND_BIT || DW <= PEND_BIT) begin : g_bad_layout
      $error("fis_int_reg: completion flags overlap the pending flag");
   end

   logic [DW-1:0] set_v;
   logic [DW-1:0] masked;
   logic [DW-1:0] nxt;

   always_comb begin
      set_v = '0;
      for (int k = 0; k < NDONE; k++) begin
         set_v[DONE_LSB + k] = done[k];
      end
      set_v[PEND_BIT] = (|done) | bad_cmd;
   end

   assign masked  = wr ? (int_q & wdata) : int_q;
   assign nxt     = masked | set_v;
   assign clr_err = wr & ~nxt[PEND_BIT];
   assign irq     = int_q[PEND_BIT] ^ ~pol_high;

   always_ff @(posedge clk) begin
      if (rst) int_q <= rst_cold ? COLD_VAL : WARM_VAL;
      else     int_q <= nxt;
   end

   // R3
   pend_on_done_chk: assert property (@(posedge clk) disable iff (rst)
      (|done) |=> int_q[PEND_BIT]);

   for (genvar k = 0; k < NDONE; k++) begin : g_done_chk
      // R3
      kind_flag_chk: assert property (@(posedge clk) disable iff (rst)
         done[k] |=> int_q[DONE_LSB + k]);
   end

   // R6
   and_write_chk: assert property (@(posedge clk) disable iff (rst)
      (wr && done == '0 && !bad_cmd) |=> int_q == ($past(int_q) & $past(wdata)));

   // R12
   event_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (wr && bad_cmd) |=> int_q[PEND_BIT]);
endmodule

// File: rtl/fis_err_reg.sv
module fis_err_reg
   import fis_pkg::*;
#(
   parameter int NERR = NUM_ERRK
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            clr,
   input  logic [NERR-1:0] err_evt,
   input  logic            bad_cmd,
   output logic [NERR:0]   err_q
);
   logic [NERR:0] set_v;
   logic [NERR:0] nxt;

   assign set_v = {err_evt, (|err_evt) | bad_cmd};
   assign nxt   = (clr ? '0 : err_q) | set_v;

   always_ff @(posedge clk) begin
      if (rst) err_q <= '0;
      else     err_q <= nxt;
   end

   // R4
   cmd_err_on_fail_chk: assert property (@(posedge clk) disable iff (rst)
      (|err_evt) |=> err_q[0]);

   // R5
   cmd_err_on_bad_chk: assert property (@(posedge clk) disable iff (rst)
      bad_cmd |=> err_q[0]);

   // R7
   wipe_chk: assert property (@(posedge clk) disable iff (rst)
      (clr && err_evt == '0 && !bad_cmd) |=> err_q == '0);

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!clr && err_evt == '0 && !bad_cmd) |=> $stable(err_q));
endmodule

// File: rtl/fis_cfg_reg.sv
module fis_cfg_reg
   import fis_pkg::*;
#(
   parameter int            DW       = REG_W,
   parameter logic [DW-1:0] CFG1_RST = 16'h40C0,
   parameter logic [DW-1:0] CFG2_RST = 16'h0000
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr1,
   input  logic          wr2,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] cfg1_q,
   output logic [DW-1:0] cfg2_q,
   output logic          ready
);
   if (DW <= RDY_BIT || DW <= POL_BIT) begin : g_bad_width
      $error("fis_cfg_reg: word too narrow for control bits");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg1_q <= CFG1_RST;
         cfg2_q <= CFG2_RST;
         ready  <= 1'b1;
      end else begin
         if (wr1) begin
            cfg1_q <= wdata;
            ready  <= wdata[RDY_BIT];
         end
         if (wr2) cfg2_q <= wdata;
      end
   end

   // R11
   ready_follow_chk: assert property (@(posedge clk) disable iff (rst)
      wr1 |=> ready == $past(wdata[RDY_BIT]));

   // R11
   ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !wr1 |=> $stable(ready));
endmodule

// File: rtl/flash_irq_status.sv
module flash_irq_status
   import fis_pkg::*;
#(
   parameter int               DW       = REG_W,
   parameter int               AW       = ADDR_W,
   parameter int               NDONE    = NUM_DONE,
   parameter int               NERR     = NUM_ERRK,
   parameter logic [DW-1:0]    INT_COLD = 16'h8080,
   parameter logic [DW-1:0]    INT_WARM = 16'h8010,
   parameter logic [DW-1:0]    CFG1_RST = 16'h40C0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rst_cold,
   input  logic             wr_en,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   input  logic [NDONE-1:0] done_evt,
   input  logic [NERR-1:0]  err_evt,
   input  logic             bad_cmd,
   output logic             cmd_go,
   output logic [DW-1:0]    cmd_code,
   output logic             cmd_accept,
   output logic             irq,
   output logic             ready
);
   localparam int ERR_TOP = ERR_LSB + NERR;
   localparam logic [DW-1:0] RD1_MASK = ~DW'((1 << RD_MASK_LO) - 1);

   if (DW != REG_W || AW < 3 || ERR_TOP >= DW) begin : g_bad_param
      $error("flash_irq_status: unsupported register geometry");
   end

   logic          wr_int, wr_cfg1, wr_cfg2, wr_cmd;
   logic [DW-1:0] int_q, cfg1_q, cfg2_q;
   logic [NERR:0] err_q;
   logic          clr_err;

   assign wr_int  = wr_en && (addr == AW'(A_INT));
   assign wr_cfg1 = wr_en && (addr == AW'(A_CFG1));
   assign wr_cfg2 = wr_en && (addr == AW'(A_CFG2));
   assign wr_cmd  = wr_en && (addr == AW'(A_CMD));

   fis_int_reg #(
      .DW(DW), .NDONE(NDONE), .COLD_VAL(INT_COLD), .WARM_VAL(INT_WARM)
   ) u_int (
      .clk(clk), .rst(rst), .rst_cold(rst_cold), .wr(wr_int), .wdata(wdata),
      .done(done_evt), .bad_cmd(bad_cmd), .pol_high(cfg1_q[POL_BIT]),
      .int_q(int_q), .clr_err(clr_err), .irq(irq)
   );

   fis_err_reg #(.NERR(NERR)) u_err (
      .clk(clk), .rst(rst), .clr(clr_err), .err_evt(err_evt),
      .bad_cmd(bad_cmd), .err_q(err_q)
   );

   fis_cfg_reg #(.DW(DW), .CFG1_RST(CFG1_RST), .CFG2_RST('0)) u_cfg (
      .clk(clk), .rst(rst), .wr1(wr_cfg1), .wr2(wr_cfg2), .wdata(wdata),
      .cfg1_q(cfg1_q), .cfg2_q(cfg2_q), .ready(ready)
   );

   assign cmd_accept = ~int_q[PEND_BIT];
   assign cmd_go     = wr_cmd & cmd_accept;

   always_ff @(posedge clk) begin
      if (rst)         cmd_code <= '0;
      else if (cmd_go) cmd_code <= wdata;
   end

   always_comb begin
      rdata = '0;
      case (addr)
         AW'(A_CTRL): rdata[ERR_LSB +: NERR+1] = err_q;
         AW'(A_INT):  rdata = int_q;
         AW'(A_CFG1): rdata = cfg1_q & RD1_MASK;
         AW'(A_CFG2): rdata = cfg2_q;
         AW'(A_CMD):  rdata = cmd_code;
         default:     rdata = '0;
      endcase
   end

   // R9
   gate_closed_chk: assert property (@(posedge clk) disable iff (rst)
      cmd_go |-> !int_q[PEND_BIT]);

   // R9
   code_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !cmd_go |=> $stable(cmd_code));

   // R8
   irq_level_chk: assert property (@(posedge clk) disable iff (rst)
      ($stable(int_q) && $stable(cfg1_q)) |-> $stable(irq));
endmodule

// File: tb/flash_irq_status_tb.sv
`timescale 1ns/100ps
module flash_irq_status_tb;
   logic        clk = 1'b0;
   logic        rst, rst_cold, wr_en, bad_cmd;
   logic [2:0]  addr;
   logic [15:0] wdata;
   logic [3:0]  done_evt;
   logic [2:0]  err_evt;
   logic [15:0] rdata, cmd_code;
   logic        cmd_go, cmd_accept, irq, ready;

   flash_irq_status u_dut (
      .clk(clk), .rst(rst), .rst_cold(rst_cold), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .done_evt(done_evt), .err_evt(err_evt),
      .bad_cmd(bad_cmd), .cmd_go(cmd_go), .cmd_code(cmd_code),
      .cmd_accept(cmd_accept), .irq(irq), .ready(ready)
   );

   always #2.5 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // bench model, built from the requirements
   logic [15:0] m_int, m_cfg1, m_cfg2, m_cmd;
   logic [3:0]  m_err;
   logic        m_rdy;

   task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_read(input int a);
      case (a)
         0: return {2'b00, m_err, 10'b0};
         1: return m_int;
         2: return m_cfg1 & 16'hFFE0;
         3: return m_cfg2;
         4: return m_cmd;
         default: return 16'h0000;
      endcase
   endfunction

   task automatic check_all(input string tag);
      string nm[8] = '{"R4 ctrl", "R3 int", "R10 cfg1", "R10 cfg2",
                       "R9 cmd", "R13 unmapped5", "R13 unmapped6", "R13 unmapped7"};
      for (int a = 0; a < 8; a++) begin
         addr = 3'(a);
         #0.1;
         chk(rdata === exp_read(a), {tag, " ", nm[a]}, rdata, exp_read(a));
      end
      chk(irq === (m_int[15] ^ ~m_cfg1[6]), {tag, " R8 irq"}, 16'(irq), 16'(m_int[15] ^ ~m_cfg1[6]));
      chk(ready === m_rdy, {tag, " R11 ready"}, 16'(ready), 16'(m_rdy));
      chk(cmd_accept === ~m_int[15], {tag, " R9 accept"}, 16'(cmd_accept), 16'(~m_int[15]));
   endtask

   task automatic clear_in();
      wr_en = 0; addr = 0; wdata = 0; done_evt = 0; err_evt = 0; bad_cmd = 0;
   endtask

   // inputs already driven; checks cmd_go, clocks, updates model, returns at next negedge
   task automatic tick();
      logic [15:0] ni;
      logic        exp_go;
      #0.1;
      exp_go = wr_en && addr == 3'd4 && !m_int[15];
      chk(cmd_go === exp_go, "R9 cmd_go", 16'(cmd_go), 16'(exp_go));
      @(posedge clk);
      ni = (wr_en && addr == 3'd1) ? (m_int & wdata) : m_int;
      for (int k = 0; k < 4; k++) if (done_evt[k]) ni[4+k] = 1'b1;
      if (done_evt != 0 || bad_cmd) ni[15] = 1'b1;
      if (wr_en && addr == 3'd1 && !ni[15]) m_err = 4'b0;
      m_err = m_err | {err_evt, (err_evt != 0) | bad_cmd};
      if (exp_go) m_cmd = wdata;
      if (wr_en && addr == 3'd2) begin m_cfg1 = wdata; m_rdy = wdata[7]; end
      if (wr_en && addr == 3'd3) m_cfg2 = wdata;
      m_int = ni;
      @(negedge clk);
      clear_in();
   endtask

   task automatic do_reset(input bit cold);
      rst = 1; rst_cold = cold;
      @(posedge clk);
      @(negedge clk);
      rst = 0; rst_cold = 0;
      m_int = cold ? 16'h8080 : 16'h8010;
      m_err = 0; m_cfg1 = 16'h40C0; m_cfg2 = 0; m_cmd = 0; m_rdy = 1;
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      wr_en = 1; addr = 3'(a); wdata = d;
      tick();
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      clear_in();
      rst = 1; rst_cold = 1;
      @(negedge clk);
      do_reset(1);
      check_all("R1 cold");

      // R6: acknowledge all
      wr(1, 16'h0000); check_all("R6 ack");

      // R3: each completion kind alone
      for (int k = 0; k < 4; k++) begin
         done_evt = 4'(1 << k); tick(); check_all("R3 done");
         wr(1, 16'h7FFF); check_all("R6 drop pend");
         wr(1, 16'h0000); check_all("R6 clear");
      end

      // R9: command refused while pending, then accepted
      done_evt = 4'b0100; tick();
      wr(4, 16'h0094); check_all("R9 refused");
      wr(1, 16'h0000);
      wr(4, 16'h0080); check_all("R9 accepted");

      // R4 each error kind, R7 keep on pending ack, then wipe
      for (int k = 0; k < 3; k++) begin
         err_evt = 3'(1 << k); done_evt = 4'(2 << k); tick(); check_all("R4 err");
         wr(1, 16'h8000); check_all("R7 keep");
         wr(1, 16'h0000); check_all("R7 wipe");
      end

      // R5: bad command
      bad_cmd = 1; tick(); check_all("R5 bad");
      wr(1, 16'h0000); check_all("R7 wipe bad");

      // R8 / R11 / R10: polarity low, ready low, masked read
      wr(2, 16'h003F); check_all("R8 pol low");
      done_evt = 4'b0001; tick(); check_all("R8 pend low");
      wr(2, 16'hFFFF); check_all("R11 ready high");
      wr(3, 16'hA5C3); check_all("R10 cfg2");

      // R12: event wins over same-cycle clear
      err_evt = 3'b010; tick();
      wr_en = 1; addr = 3'd1; wdata = 16'h0000; done_evt = 4'b1000; tick();
      check_all("R12 same cycle");
      wr_en = 1; addr = 3'd1; wdata = 16'h0000; bad_cmd = 1; tick();
      check_all("R12 bad same cycle");

      // R13: writes to status and unmapped addresses do nothing
      wr(0, 16'hFFFF); wr(5, 16'hFFFF); wr(7, 16'h1234); check_all("R13 ignored");

      // R2: warm reset
      @(negedge clk);
      do_reset(0);
      check_all("R2 warm");

      // random traffic
      for (int i = 0; i < 600; i++) begin
         wr_en = ($urandom % 2) == 0;
         addr  = 3'($urandom % 6);
         wdata = 16'($urandom);
         if (addr == 3'd1 && ($urandom % 2) == 0) wdata = 16'(wdata & 16'h7FFF);
         done_evt = (($urandom % 8) == 0) ? 4'(1 << ($urandom % 4)) : 4'b0;
         err_evt  = (($urandom % 10) == 0) ? 3'(1 << ($urandom % 3)) : 3'b0;
         bad_cmd  = ($urandom % 16) == 0;
         tick();
         check_all("R6 rnd");
      end

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule